// File: doc/BRIEF.md
# OS Context Push with Saved Pending-Bit Replay

This block sits on the dispatch path of a per-thread interrupt presenter. When a hypervisor-privileged 4-byte store lands on word 2 of the OS ring, the block loads the 32-bit value into the OS context line. It also decodes a valid flag, a block number and a processor index from that value. If the flag is set and the pair names a record held locally, the block reads word 4 of that record from an external table. The table answers one cycle after each read.

A nonzero saved pending field is cleared in the table with a single write-back of word 4. The saved bits are then OR-merged into the live OS pending register. This re-raises interrupts that arrived while the processor was not dispatched. After each merge the block updates an exception-pending output. That output compares the most favoured pending priority with the current priority input.

While the sequence runs, `busy` is high and `st_ready` is low, so any further push is refused.

Top module: `ctx_push_resend`

## Requirements
- R1: A store is taken as a push only when `st_valid`, `st_ready` and `st_hv` are 1, `st_ring` is 1 (OS ring), `st_word` is 2 and `st_size` is 4 (bytes). Any other store changes no output and no table word.
- R2: On an accepted push, `ctx_line` holds `st_data` from the next cycle on.
- R3: The pushed value decodes as valid = bit 31, block = bits 22:19 and index = bits 18:0.
- R4: With the valid bit clear, only `ctx_line` changes: no table access takes place, and `busy` stays low.
- R5: A record exists only when block equals `HOME_BLK` (default 2) and index < `NREC` (16). A valid push naming no record pulses `rec_err` for exactly the one cycle after the accept. It makes no table access, and it leaves `live_pend` unchanged.
- R6: For an existing record, `mem_rd_en` is high in the cycle after the accept, with `mem_addr` = index*8 + 4. `mem_rdata` is taken one cycle later.
- R7: The saved pending field is bits 15:8 of word 4. When it is nonzero, exactly one write follows, to the same address, with that field zero and all other bits unchanged.
- R8: When the saved field is zero, no write and no merge happen.
- R9: The merge ORs the saved field into `live_pend`, so set bits are kept. `pend_set` bits are also ORed in every cycle, and no bit of `live_pend` is ever cleared.
- R10: In the cycle after each merge, `exc_pend` becomes 1 exactly when the lowest set bit index of the new `live_pend` is below `cur_prio`. It holds that value until the next merge.
- R11: `busy` is high for 3 cycles on the merge path, for 2 cycles on the zero-field path, and for 0 cycles otherwise. While `busy` is high, `st_ready` is low, and a store then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | High when a store can be taken |
| st_hv | input | 1 | Store comes through the hypervisor-privileged view |
| st_ring | input | 2 | Ring selected by the store (1 = OS) |
| st_word | input | 2 | Word within the ring |
| st_size | input | 3 | Store size in bytes |
| st_data | input | 32 | Store data |
| pend_set | input | 8 | Pending bits raised by other sources |
| cur_prio | input | 3 | Current priority threshold |
| mem_rd_en | output | 1 | Table read strobe |
| mem_wr_en | output | 1 | Table write strobe |
| mem_addr | output | 7 | Table word address (record*8 + word) |
| mem_wdata | output | 32 | Table write data |
| mem_rdata | input | 32 | Table read data, one cycle after the read |
| ctx_line | output | 32 | OS context line register |
| live_pend | output | 8 | Live OS pending bits |
| exc_pend | output | 1 | Exception pending after the last merge |
| busy | output | 1 | Resend sequence running |
| rec_err | output | 1 | One-cycle pulse for a push naming no record |

## Verification
An accepted push shows in `ctx_line`, and for a missing record in `rec_err`, one cycle after the accepting edge. The bench samples both at the first falling edge after that edge. It then counts the falling edges on which `busy` is high and compares the count with 3, 2 or 0 for the path it expects. Only when `busy` has dropped does it compare `live_pend`, `exc_pend` and the table word, since the merge edge is the last busy cycle. A push made during `busy` is checked by confirming `st_ready` is low and that `ctx_line` keeps the first value.

// File: rtl/ctxr_pkg.sv
package ctxr_pkg;
    parameter int CAM_W     = 32;
    parameter int CAM_BLK_W = 4;
    parameter int CAM_IDX_W = 19;
    parameter int CAM_VLD_B = 31;
    parameter int CAM_BLK_L = 19;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD   = 2'd1,
        S_CHK  = 2'd2,
        S_WB   = 2'd3
    } st_e;

    typedef struct packed {
        logic                 vld;
        logic [CAM_BLK_W-1:0] blk;
        logic [CAM_IDX_W-1:0] idx;
    } cam_t;
endpackage

// File: rtl/push_decode.sv
module push_decode import ctxr_pkg::*; #(
    parameter logic [1:0] RING_OS  = 2'd1,
    parameter logic [1:0] WORD_CTX = 2'd2,
    parameter logic [2:0] SIZE_W   = 3'd4
) (
    input  logic             st_valid,
    input  logic             idle,
    input  logic             st_hv,
    input  logic [1:0]       st_ring,
    input  logic [1:0]       st_word,
    input  logic [2:0]       st_size,
    input  logic [CAM_W-1:0] st_data,
    output logic             hit,
    output cam_t             cam
);
    always_comb begin
        hit = st_valid && idle && st_hv && (st_ring == RING_OS)
              && (st_word == WORD_CTX) && (st_size == SIZE_W);
        cam.vld = st_data[CAM_VLD_B];
        cam.blk = st_data[CAM_BLK_L +: CAM_BLK_W];
        cam.idx = st_data[CAM_IDX_W-1:0];
    end
endmodule

// File: rtl/rec_locate.sv
module rec_locate import ctxr_pkg::*; #(
    parameter int                   NREC      = 16,
    parameter int                   REC_WORDS = 8,
    parameter int                   PEND_WORD = 4,
    parameter logic [CAM_BLK_W-1:0] HOME_BLK  = 4'd2,
    localparam int REC_W  = $clog2(NREC),
    localparam int WSEL_W = $clog2(REC_WORDS),
    localparam int ADDR_W = REC_W + WSEL_W
) (
    input  logic [CAM_BLK_W-1:0] blk,
    input  logic [CAM_IDX_W-1:0] idx,
    output logic                 ok,
    output logic [ADDR_W-1:0]    addr
);
    localparam logic [CAM_IDX_W-1:0] IDX_LIM = CAM_IDX_W'(NREC);
    localparam logic [WSEL_W-1:0]    WSEL    = WSEL_W'(PEND_WORD);

    always_comb begin
        ok   = (blk == HOME_BLK) && (idx < IDX_LIM);
        addr = {idx[REC_W-1:0], WSEL};
    end
endmodule

// File: rtl/pend_merge.sv
module pend_merge #(
    parameter int PEND_W = 8,
    localparam int PRIO_W = $clog2(PEND_W)
) (
    input  logic [PEND_W-1:0] base,
    input  logic [PEND_W-1:0] add,
    input  logic [PRIO_W-1:0] prio,
    output logic [PEND_W-1:0] merged,
    output logic              exc
);
    logic [PRIO_W-1:0] best;
    logic              any;

    always_comb begin
        merged = base | add;
        best   = '0;
        any    = 1'b0;
        for (int i = PEND_W - 1; i >= 0; i--) begin
            if (merged[i]) begin
                best = PRIO_W'(i);
                any  = 1'b1;
            end
        end
        exc = any && (best < prio);
    end
endmodule

// File: rtl/ctx_push_resend.sv
module ctx_push_resend import ctxr_pkg::*; #(
    parameter int                   PEND_W    = 8,
    parameter int                   NREC      = 16,
    parameter int                   REC_WORDS = 8,
    parameter int                   PEND_WORD = 4,
    parameter int                   PEND_LSB  = 8,
    parameter logic [CAM_BLK_W-1:0] HOME_BLK  = 4'd2,
    localparam int PRIO_W = $clog2(PEND_W),
    localparam int ADDR_W = $clog2(NREC) + $clog2(REC_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic              st_hv,
    input  logic [1:0]        st_ring,
    input  logic [1:0]        st_word,
    input  logic [2:0]        st_size,
    input  logic [CAM_W-1:0]  st_data,
    input  logic [PEND_W-1:0] pend_set,
    input  logic [PRIO_W-1:0] cur_prio,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CAM_W-1:0]  mem_wdata,
    input  logic [CAM_W-1:0]  mem_rdata,
    output logic [CAM_W-1:0]  ctx_line,
    output logic [PEND_W-1:0] live_pend,
    output logic              exc_pend,
    output logic              busy,
    output logic              rec_err
);
    localparam logic [CAM_W-1:0] FIELD_MASK =
        CAM_W'(((64'd1 << PEND_W) - 64'd1) << PEND_LSB);
    localparam int WSEL_W = $clog2(REC_WORDS);

    typedef struct packed {
        st_e               st;
        logic [CAM_W-1:0]  ctx;
        logic [ADDR_W-1:0] addr;
        logic [PEND_W-1:0] saved;
        logic [CAM_W-1:0]  wb;
        logic [PEND_W-1:0] pend;
        logic              exc;
        logic              err;
    } regs_t;

    regs_t r_q, r_d;

    logic              push_hit;
    cam_t              cam;
    logic              rec_ok;
    logic [ADDR_W-1:0] rec_addr;
    logic [PEND_W-1:0] merged;
    logic              merge_exc;
    logic [PEND_W-1:0] field;

    push_decode u_dec (
        .st_valid (st_valid),
        .idle     (r_q.st == S_IDLE),
        .st_hv    (st_hv),
        .st_ring  (st_ring),
        .st_word  (st_word),
        .st_size  (st_size),
        .st_data  (st_data),
        .hit      (push_hit),
        .cam      (cam)
    );

    rec_locate #(
        .NREC      (NREC),
        .REC_WORDS (REC_WORDS),
        .PEND_WORD (PEND_WORD),
        .HOME_BLK  (HOME_BLK)
    ) u_loc (
        .blk  (cam.blk),
        .idx  (cam.idx),
        .ok   (rec_ok),
        .addr (rec_addr)
    );

    pend_merge #(.PEND_W(PEND_W)) u_mrg (
        .base   (r_q.pend | pend_set),
        .add    (r_q.saved),
        .prio   (cur_prio),
        .merged (merged),
        .exc    (merge_exc)
    );

    assign field = mem_rdata[PEND_LSB +: PEND_W];

    always_comb begin
        r_d      = r_q;
        r_d.err  = 1'b0;
        r_d.pend = r_q.pend | pend_set;
        case (r_q.st)
            S_IDLE: begin
                if (push_hit) begin
                    r_d.ctx = st_data;
                    if (cam.vld) begin
                        if (rec_ok) begin
                            r_d.st   = S_RD;
                            r_d.addr = rec_addr;
                        end else begin
                            r_d.err = 1'b1;
                        end
                    end
                end
            end
            S_RD: r_d.st = S_CHK;
            S_CHK: begin
                if (field != '0) begin
                    r_d.saved = field;
                    r_d.wb    = mem_rdata & ~FIELD_MASK;
                    r_d.st    = S_WB;
                end else begin
                    r_d.st = S_IDLE;
                end
            end
            S_WB: begin
                r_d.pend = merged;
                r_d.exc  = merge_exc;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_ready  = (r_q.st == S_IDLE);
    assign busy      = (r_q.st != S_IDLE);
    assign mem_rd_en = (r_q.st == S_RD);
    assign mem_wr_en = (r_q.st == S_WB);
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wb;
    assign ctx_line  = r_q.ctx;
    assign live_pend = r_q.pend;
    assign exc_pend  = r_q.exc;
    assign rec_err   = r_q.err;

    p_ctx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_hit |=> ctx_line == $past(st_data));

    p_no_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_hit && !st_data[CAM_VLD_B]) |=> !busy && !mem_rd_en);

    p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rec_err |-> !busy && !mem_rd_en && !mem_wr_en);

    p_read_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en, 2) && $stable(mem_addr));

    p_wb_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr[WSEL_W-1:0] == WSEL_W'(PEND_WORD))
                      && ((mem_wdata & FIELD_MASK) == '0));

    p_keep_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (live_pend & $past(live_pend)) == $past(live_pend));

    p_exc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(exc_pend) |-> $past(mem_wr_en));

    p_refuse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_valid) |=> $stable(ctx_line));
endmodule

// File: tb/test_ctx_push_resend.sv
module test_ctx_push_resend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, st_hv = 1'b0;
    logic [1:0]  st_ring = '0, st_word = '0;
    logic [2:0]  st_size = '0;
    logic [31:0] st_data = '0;
    logic [7:0]  pend_set = '0;
    logic [2:0]  cur_prio = '0;
    logic        st_ready, mem_rd_en, mem_wr_en, exc_pend, busy, rec_err;
    logic [6:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata, ctx_line;
    logic [7:0]  live_pend;

    logic        pl_en = 1'b0;
    logic [6:0]  pl_addr = '0;
    logic [31:0] pl_data = '0;
    logic [31:0] tmem [128];
    logic [31:0] ref_mem [128];
    int          n_rd, n_wr;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctx_push_resend i_ctx_push_resend (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_hv(st_hv), .st_ring(st_ring), .st_word(st_word), .st_size(st_size),
        .st_data(st_data), .pend_set(pend_set), .cur_prio(cur_prio),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ctx_line(ctx_line),
        .live_pend(live_pend), .exc_pend(exc_pend), .busy(busy), .rec_err(rec_err)
    );

    always @(posedge clk) begin
        if (pl_en) tmem[pl_addr] <= pl_data;
        if (mem_wr_en) begin
            tmem[mem_addr] <= mem_wdata;
            n_wr <= n_wr + 1;
        end
        if (mem_rd_en) begin
            mem_rdata <= tmem[mem_addr];
            n_rd <= n_rd + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_exc(input logic [7:0] p, input logic [2:0] prio);
        for (int i = 0; i < 8; i++) if (p[i]) return (i < int'(prio));
        return 1'b0;
    endfunction

    task automatic preload(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        pl_en = 1'b1; pl_addr = a; pl_data = d;
        ref_mem[a] = d;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    logic [31:0] e_ctx;
    logic [7:0]  e_pend;
    logic        e_exc;

    // one store, then checks of every result at its due cycle
    task automatic store(input logic hv, input logic [1:0] ring, input logic [1:0] word,
                         input logic [2:0] size, input logic [31:0] d);
        logic acc, vld, ok;
        logic [6:0] a;
        logic [7:0] fld;
        int exp_busy, nb, rd0, wr0;
        acc = hv && ring == 2'd1 && word == 2'd2 && size == 3'd4;
        vld = d[31];
        ok  = d[22:19] == 4'd2 && d[18:0] < 19'd16;
        a   = {d[3:0], 3'd4};
        fld = ref_mem[a][15:8];
        rd0 = n_rd; wr0 = n_wr;
        @(negedge clk);
        st_valid = 1'b1; st_hv = hv; st_ring = ring; st_word = word;
        st_size = size; st_data = d;
        @(negedge clk);
        st_valid = 1'b0;
        if (acc) e_ctx = d;
        chk("R2 ctx_line", ctx_line, e_ctx);
        chk("R5 rec_err", {31'd0, rec_err}, {31'd0, acc && vld && !ok});
        exp_busy = 0;
        if (acc && vld && ok) exp_busy = (fld != 8'd0) ? 3 : 2;
        nb = 0;
        while (busy && nb < 20) begin
            nb++;
            @(negedge clk);
        end
        chk("R11 busy cycles", nb, exp_busy);
        chk("R6 reads", n_rd - rd0, (exp_busy != 0) ? 1 : 0);
        chk("R7 R8 writes", n_wr - wr0, (exp_busy == 3) ? 1 : 0);
        if (exp_busy == 3) begin
            ref_mem[a][15:8] = 8'd0;
            e_pend = e_pend | fld;
            e_exc  = exp_exc(e_pend, cur_prio);
        end
        chk("R7 table word4", tmem[a], ref_mem[a]);
        chk("R9 live_pend", {24'd0, live_pend}, {24'd0, e_pend});
        chk("R10 exc_pend", {31'd0, exc_pend}, {31'd0, e_exc});
    endtask

    function automatic logic [31:0] mk(input logic v, input logic [3:0] b, input logic [18:0] i);
        return {v, 8'($urandom), b, i};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        n_rd = 0; n_wr = 0;
        for (int i = 0; i < 128; i++) begin
            tmem[i] = 32'h0;
            ref_mem[i] = 32'h0;
        end
        e_ctx = '0; e_pend = '0; e_exc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset ctx_line", ctx_line, 32'h0);
        chk("R9 reset live_pend", {24'd0, live_pend}, 32'h0);
        chk("R11 reset ready/busy", {30'd0, st_ready, busy}, 32'h2);
        chk("R6 reset mem strobes", {30'd0, mem_rd_en, mem_wr_en}, 32'h0);

        // directed: merge into set bits, check OR and priority
        cur_prio = 3'd3;
        preload(7'd44, 32'hA5A5_10C3);          // record 5 word 4, field 0x10
        @(negedge clk); pend_set = 8'h81;
        @(negedge clk); pend_set = 8'h00; e_pend = 8'h81;
        store(1'b1, 2'd1, 2'd2, 3'd4, mk(1'b1, 4'd2, 19'd5));   // R9 keeps 0x81
        chk("R9 or-merge", {24'd0, live_pend}, 32'h91);
        chk("R10 lowest bit 0 < 3", {31'd0, exc_pend}, 32'h1);

        // zero field: no write, no merge (R8)
        preload(7'd12, 32'h1234_0078);
        store(1'b1, 2'd1, 2'd2, 3'd4, mk(1'b1, 4'd2, 19'd1));
        // valid clear (R4), wrong views (R1), missing records (R5)
        preload(7'd60, 32'h0000_4400);
        store(1'b1, 2'd1, 2'd2, 3'd4, mk(1'b0, 4'd2, 19'd7));
        store(1'b0, 2'd1, 2'd2, 3'd4, mk(1'b1, 4'd2, 19'd7));
        store(1'b1, 2'd1, 2'd2, 3'd1, mk(1'b1, 4'd2, 19'd7));
        store(1'b1, 2'd3, 2'd2, 3'd4, mk(1'b1, 4'd2, 19'd7));
        store(1'b1, 2'd1, 2'd0, 3'd4, mk(1'b1, 4'd2, 19'd7));
        store(1'b1, 2'd1, 2'd2, 3'd4, mk(1'b1, 4'd3, 19'd7));
        store(1'b1, 2'd1, 2'd2, 3'd4, mk(1'b1, 4'd2, 19'd16));
        // R3 decode: index bits above the record bits make it missing
        store(1'b1, 2'd1, 2'd2, 3'd4, {1'b1, 8'h00, 4'd2, 19'h40007});

        // R11 refused push while busy
        preload(7'd28, 32'h0000_0200);           // record 3, field 0x02
        @(negedge clk);
        st_valid = 1'b1; st_hv = 1'b1; st_ring = 2'd1; st_word = 2'd2;
        st_size = 3'd4; st_data = mk(1'b1, 4'd2, 19'd3); e_ctx = st_data;
        @(negedge clk);
        st_data = 32'h8010_0009;
        chk("R11 ready low when busy", {31'd0, st_ready}, 32'h0);
        @(negedge clk);
        st_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 refused push ctx", ctx_line, e_ctx);
        ref_mem[28][15:8] = 8'd0;
        e_pend = e_pend | 8'h02;
        e_exc  = exp_exc(e_pend, cur_prio);
        chk("R7 refused-case word4", tmem[28], ref_mem[28]);
        chk("R9 refused-case pend", {24'd0, live_pend}, {24'd0, e_pend});

        // random mix
        for (int n = 0; n < 150; n++) begin
            logic [3:0]  b;
            logic [18:0] ix;
            logic        hv;
            logic [1:0]  rg, wd;
            logic [2:0]  sz;
            ix = ($urandom % 6 == 0) ? 19'(16 + $urandom % 1000) : 19'($urandom % 16);
            b  = ($urandom % 4 == 0) ? 4'($urandom) : 4'd2;
            if ($urandom % 2 == 0)
                preload({ix[3:0], 3'd4}, $urandom);
            if ($urandom % 8 == 0) begin
                @(negedge clk); pend_set = 8'd1 << ($urandom % 8);
                e_pend = e_pend | pend_set;
                @(negedge clk); pend_set = 8'h00;
            end
            cur_prio = 3'($urandom);
            hv = 1'b1; rg = 2'd1; wd = 2'd2; sz = 3'd4;
            if ($urandom % 10 == 0) begin
                case ($urandom % 4)
                    0: hv = 1'b0;
                    1: rg = 2'd0;
                    2: wd = 2'd3;
                    default: sz = 3'd2;
                endcase
            end
            store(hv, rg, wd, sz, mk(($urandom % 5) != 0, b, ix));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule